// File: doc/BRIEF.md
# Two-Level Counted Burst DMA Channel

This block is one DMA channel. It moves data from memory into a single peripheral address, such as the data port of a transmit FIFO. Each service of the channel is a burst of 4-byte beats. Every beat reads one word at the current source pointer and writes that word to the fixed destination. The burst length comes from an inner beat count. An outer burst count sets how many bursts the channel runs before it finishes.

A burst starts on one of two triggers. The first is a pulse on the peripheral request line, which the peripheral raises when its FIFO runs empty. The second is a software start bit in the control register. Software uses it once to fill the FIFO before the first empty event, and that burst counts toward the outer total. A request that arrives during a burst is held as one pending flag. When the last burst finishes, the channel raises a level interrupt and then ignores further triggers.

Top module: `burst_dma_channel`

## Requirements
- R1: After reset, memReq, memWe and irqDone are all low, and the channel starts no transfer.
- R2: A burst is a series of beats. Each beat is one read (memWe=0) at the source pointer, accepted when memReq and memReady are both high. The word read is then written (memWe=1) to the destination register's address. A read is always followed by its write.
- R3: If ctrl bit 3 (step) is 1, the source pointer grows by 4 each time a write is accepted. If the bit is 0, every read uses the programmed source. The write address always equals the destination register.
- R4: Register 2 sets the number of beats per burst, and every burst reloads it. Register 3 sets the number of bursts. In both registers a value of 0 means 2**CNT_W.
- R5: After the programmed number of bursts, the channel issues no more memory cycles, whatever requests arrive, until register 3 is written again.
- R6: A ctrl write with bit 1 (start) and bit 0 (enable) both set runs one burst with no hardware request, and that burst counts toward the burst total.
- R7: While enable (ctrl bit 0) is 0, hwReq pulses are dropped and not remembered. Writing enable=0 during a burst removes memReq by the next cycle and clears irqDone.
- R8: Requests that arrive while a burst is in progress collapse into a single pending request, which runs one more burst after the current one ends.
- R9: irqDone rises when the final burst ends. It stays high until a ctrl write sets bit 2 (clear) or clears enable.
- R10: While a cycle waits for memReady, memReq, memWe and memAddr stay unchanged. The next beat's read is not issued before the current write has been accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cpuWe | input | 1 | Register write strobe |
| cpuAddr | input | 3 | Register index: 0 source, 1 destination, 2 beat count, 3 burst count, 4 control |
| cpuWdata | input | 32 | Register write data |
| hwReq | input | 1 | Peripheral request pulse (FIFO empty) |
| memReq | output | 1 | Memory cycle request |
| memWe | output | 1 | 1 for a write cycle, 0 for a read cycle |
| memAddr | output | AW | Memory cycle address |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid in the accepting cycle |
| memReady | input | 1 | Memory accepts the current cycle |
| irqDone | output | 1 | Level completion interrupt |

## Verification
Two events can land in the same cycle: the software start write and a peripheral request pulse. The bench first enables the channel without starting it. It then drives both events in one cycle on a channel with a two-burst total. It passes only if exactly two bursts' worth of beats appear and the completion interrupt rises, which shows that neither trigger was lost and neither was counted twice. Random memory stalls throughout the run make burst ends overlap with requests arriving in the middle of a burst.

// File: rtl/burst_dma_pkg.sv
package burst_dma_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} dmaState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic grab;     // read accepted, capture word
    logic step;     // write accepted, advance pointer
    logic wrPhase;  // address mux selects destination
  } dpStrobes_t;

  localparam logic [2:0] REG_SRC  = 3'd0;
  localparam logic [2:0] REG_DST  = 3'd1;
  localparam logic [2:0] REG_BEAT = 3'd2;
  localparam logic [2:0] REG_BRST = 3'd3;
  localparam logic [2:0] REG_CTRL = 3'd4;

  localparam int CTL_EN    = 0;
  localparam int CTL_START = 1;
  localparam int CTL_CLR   = 2;
  localparam int CTL_STEP  = 3;
endpackage

// File: rtl/burst_dma_dp.sv
module burst_dma_dp
  import burst_dma_pkg::*;
#(
  parameter int AW   = 32,
  parameter int DW   = 32,
  parameter int BEAT = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          srcLd,
  input  logic          dstLd,
  input  logic [AW-1:0] ldVal,
  input  logic          srcStep,
  input  dpStrobes_t    strb,
  input  logic [DW-1:0] memRdata,
  output logic [AW-1:0] memAddr,
  output logic [DW-1:0] memWdata
);
  localparam logic [AW-1:0] STRIDE = AW'(BEAT);

  logic [AW-1:0] srcPtr;
  logic [AW-1:0] dstAddr;
  logic [DW-1:0] dataReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcPtr  <= '0;
      dstAddr <= '0;
      dataReg <= '0;
    end else begin
      if (strb.grab) dataReg <= memRdata;
      if (strb.step && srcStep) srcPtr <= srcPtr + STRIDE;
      if (srcLd) srcPtr <= ldVal;
      if (dstLd) dstAddr <= ldVal;
    end
  end

  assign memAddr  = strb.wrPhase ? dstAddr : srcPtr;
  assign memWdata = dataReg;
endmodule

// File: rtl/burst_dma_ctl.sv
module burst_dma_ctl
  import burst_dma_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cpuWe,
  input  logic [2:0]  cpuAddr,
  input  logic [31:0] cpuWdata,
  input  logic        hwReq,
  input  logic        memReady,
  output logic        memReq,
  output logic        memWe,
  output logic        srcLd,
  output logic        dstLd,
  output logic        srcStep,
  output logic        chanEn,
  output logic        irqDone,
  output dpStrobes_t  strb
);
  localparam int CW = CNT_W + 1;
  localparam logic [CW-1:0] ONE = CW'(1);

  dmaState_e     state;
  logic [CNT_W-1:0] beatProg;
  logic [CW-1:0] beatsLeft;
  logic [CW-1:0] burstsLeft;
  logic          hwPend;
  logic          swPend;
  logic          wrCtl;
  logic [CW-1:0] beatLoad;
  logic [CW-1:0] burstLoad;

  // zero in a count register means the full range
  assign beatLoad  = {(beatProg == '0), beatProg};
  assign burstLoad = {(cpuWdata[CNT_W-1:0] == '0), cpuWdata[CNT_W-1:0]};
  assign wrCtl     = cpuWe && (cpuAddr == REG_CTRL);
  assign srcLd     = cpuWe && (cpuAddr == REG_SRC);
  assign dstLd     = cpuWe && (cpuAddr == REG_DST);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      beatProg   <= '0;
      beatsLeft  <= '0;
      burstsLeft <= '0;
      hwPend     <= 1'b0;
      swPend     <= 1'b0;
      chanEn     <= 1'b0;
      srcStep    <= 1'b0;
      irqDone    <= 1'b0;
    end else begin
      if (!chanEn) begin
        state   <= ST_IDLE;
        hwPend  <= 1'b0;
        swPend  <= 1'b0;
        irqDone <= 1'b0;
      end else begin
        unique case (state)
          ST_IDLE: begin
            if ((hwPend || swPend) && burstsLeft != '0) begin
              state     <= ST_READ;
              beatsLeft <= beatLoad;
              if (swPend) swPend <= 1'b0;
              else        hwPend <= 1'b0;
            end
          end
          ST_READ: if (memReady) state <= ST_WRITE;
          ST_WRITE: begin
            if (memReady) begin
              if (beatsLeft == ONE) begin
                state      <= ST_IDLE;
                burstsLeft <= burstsLeft - ONE;
                if (burstsLeft == ONE) irqDone <= 1'b1;
              end else begin
                beatsLeft <= beatsLeft - ONE;
                state     <= ST_READ;
              end
            end
          end
          default: state <= ST_IDLE;
        endcase
        if (hwReq) hwPend <= 1'b1;
      end
      // register writes take precedence over channel updates
      if (cpuWe && cpuAddr == REG_BEAT) beatProg   <= cpuWdata[CNT_W-1:0];
      if (cpuWe && cpuAddr == REG_BRST) burstsLeft <= burstLoad;
      if (wrCtl) begin
        chanEn  <= cpuWdata[CTL_EN];
        srcStep <= cpuWdata[CTL_STEP];
        if (cpuWdata[CTL_CLR] || !cpuWdata[CTL_EN]) irqDone <= 1'b0;
        if (!cpuWdata[CTL_EN]) begin
          hwPend <= 1'b0;
          swPend <= 1'b0;
        end
        if (cpuWdata[CTL_START] && cpuWdata[CTL_EN]) swPend <= 1'b1;
      end
    end
  end

  assign memReq       = chanEn && (state != ST_IDLE);
  assign memWe        = (state == ST_WRITE);
  assign strb.grab    = chanEn && (state == ST_READ) && memReady;
  assign strb.step    = chanEn && (state == ST_WRITE) && memReady;
  assign strb.wrPhase = (state == ST_WRITE);
endmodule

// File: rtl/burst_dma_channel.sv
module burst_dma_channel
  import burst_dma_pkg::*;
#(
  parameter int AW    = 32,
  parameter int CNT_W = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuWe,
  input  logic [2:0]    cpuAddr,
  input  logic [31:0]   cpuWdata,
  input  logic          hwReq,
  output logic          memReq,
  output logic          memWe,
  output logic [AW-1:0] memAddr,
  output logic [31:0]   memWdata,
  input  logic [31:0]   memRdata,
  input  logic          memReady,
  output logic          irqDone
);
  dpStrobes_t strb;
  logic srcLd, dstLd, srcStep, chanEn;

  burst_dma_ctl #(.CNT_W(CNT_W)) ctl_i (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .hwReq(hwReq), .memReady(memReady), .memReq(memReq), .memWe(memWe),
    .srcLd(srcLd), .dstLd(dstLd), .srcStep(srcStep), .chanEn(chanEn),
    .irqDone(irqDone), .strb(strb)
  );

  burst_dma_dp #(.AW(AW), .DW(32), .BEAT(4)) dp_i (
    .clk(clk), .rstN(rstN), .srcLd(srcLd), .dstLd(dstLd), .ldVal(cpuWdata[AW-1:0]),
    .srcStep(srcStep), .strb(strb), .memRdata(memRdata),
    .memAddr(memAddr), .memWdata(memWdata)
  );
endmodule

// File: rtl/burst_dma_channel_sva.sv
module burst_dma_channel_sva
  import burst_dma_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuWe,
  input logic [2:0]    cpuAddr,
  input logic [31:0]   cpuWdata,
  input logic          memReq,
  input logic          memWe,
  input logic [AW-1:0] memAddr,
  input logic          memReady,
  input logic          chanEn,
  input logic          irqDone
);
  // R10: a stalled cycle holds its request, direction and address
  a_r10_hold_stall: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> !chanEn || (memReq && $stable(memWe) && $stable(memAddr)));

  // R2: an accepted read is followed by the write of that beat
  a_r2_read_then_write: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memReady && !memWe |=> !chanEn || (memReq && memWe));

  // R9: the completion flag only drops through clear or disable
  a_r9_irq_level: assert property (@(posedge clk) disable iff (!rstN)
    irqDone |=> irqDone || !chanEn ||
      $past(cpuWe && cpuAddr == REG_CTRL && (cpuWdata[CTL_CLR] || !cpuWdata[CTL_EN])));

  // R5: once done and idle, no new cycle starts without a register write
  a_r5_quiet_after_done: assert property (@(posedge clk) disable iff (!rstN)
    irqDone && !memReq && !cpuWe |=> !memReq);

  // R7: a disabled channel never requests the bus
  a_r7_off_no_req: assert property (@(posedge clk) disable iff (!rstN)
    !chanEn && !cpuWe |=> !memReq);
endmodule

bind burst_dma_channel burst_dma_channel_sva #(.AW(AW)) sva_i (
  .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
  .memReq(memReq), .memWe(memWe), .memAddr(memAddr), .memReady(memReady),
  .chanEn(chanEn), .irqDone(irqDone)
);

// File: tb/burst_dma_channel_tb_top.sv
module burst_dma_channel_tb_top;
  localparam int CNT_W = 8;
  localparam int FULL  = 1 << CNT_W;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cpuWe = 1'b0;
  logic [2:0]  cpuAddr = '0;
  logic [31:0] cpuWdata = '0;
  logic        hwReq = 1'b0;
  logic        memReq, memWe, irqDone;
  logic [31:0] memAddr, memWdata;
  logic [31:0] memRdata = '0;
  logic        memReady = 1'b0;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // monitor state
  logic [31:0] expSrc, expDst, lastRd;
  bit stepOn, rdPending;
  int nRead, nWrite, monErr;

  always #2 clk = ~clk;

  burst_dma_channel #(.AW(32), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rstN(rstN), .cpuWe(cpuWe), .cpuAddr(cpuAddr), .cpuWdata(cpuWdata),
    .hwReq(hwReq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady), .irqDone(irqDone)
  );

  function automatic logic [31:0] wordAt(logic [31:0] a);
    return a ^ 32'hC3C3_0F0F;
  endfunction

  function automatic logic [6:0] ctl(bit en, bit start, bit clr, bit stp);
    return {3'b0, stp, clr, start, en};
  endfunction

  // memory model: acts at negedge, logs the handshake completing at the next edge
  always @(negedge clk) begin
    if (rstN) begin
      memReady = ($urandom % 4) != 0;
      memRdata = wordAt(memAddr);
      if (memReq && memReady) begin
        if (!memWe) begin
          if (rdPending) monErr++;
          if (memAddr !== expSrc) monErr++;
          lastRd = memRdata;
          rdPending = 1;
          nRead++;
        end else begin
          if (!rdPending) monErr++;
          if (memAddr !== expDst || memWdata !== lastRd) monErr++;
          rdPending = 0;
          if (stepOn) expSrc = expSrc + 32'd4;
          nWrite++;
        end
      end
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cpuWr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = a; cpuWdata = d;
    @(negedge clk);
    cpuWe = 1'b0;
  endtask

  task automatic pulseReq();
    @(negedge clk); hwReq = 1'b1;
    @(negedge clk); hwReq = 1'b0;
  endtask

  task automatic waitQuiet();
    int q = 0;
    while (q < 6) begin
      @(negedge clk);
      if (memReq) q = 0; else q++;
    end
  endtask

  task automatic prog(logic [31:0] s, logic [31:0] d, int a, int b, bit stp);
    cpuWr(3'd4, 32'd0);
    cpuWr(3'd0, s);
    cpuWr(3'd1, d);
    cpuWr(3'd2, 32'(a));
    cpuWr(3'd3, 32'(b));
    expSrc = s; expDst = d; stepOn = stp;
    rdPending = 0; nRead = 0; nWrite = 0; monErr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    expSrc = 0; expDst = 0; lastRd = 0; stepOn = 0; rdPending = 0;
    nRead = 0; nWrite = 0; monErr = 0;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(!memReq && !memWe && !irqDone, "R1 reset outputs", int'({memReq, memWe, irqDone}), 0);

    // directed: 4 beats x 3 bursts, soft start then two requests
    prog(32'h1000, 32'h8000, 4, 3, 1);
    cpuWr(3'd4, 32'(ctl(1, 1, 0, 1)));
    waitQuiet();
    check(nWrite == 4, "R6 soft start runs one burst", nWrite, 4);
    check(!irqDone, "R9 no irq before last burst", irqDone, 0);
    pulseReq(); waitQuiet();
    pulseReq(); waitQuiet();
    check(nWrite == 12, "R2 beats total", nWrite, 12);
    check(nRead == 12, "R2 reads total", nRead, 12);
    check(monErr == 0, "R3 incrementing addresses and data", monErr, 0);
    check(irqDone, "R9 irq at final burst", irqDone, 1);
    pulseReq(); waitQuiet(); pulseReq(); waitQuiet();
    check(nWrite == 12, "R5 no beats after last burst", nWrite, 12);
    check(irqDone, "R9 irq held", irqDone, 1);
    cpuWr(3'd4, 32'(ctl(1, 0, 1, 1)));
    check(!irqDone, "R9 clear bit drops irq", irqDone, 0);

    // fixed source
    prog(32'h2200, 32'h9000, 3, 1, 0);
    cpuWr(3'd4, 32'(ctl(1, 1, 0, 0)));
    waitQuiet();
    check(nWrite == 3 && monErr == 0, "R3 fixed source", monErr, 0);

    // requests during a burst collapse
    prog(32'h3000, 32'h9100, 8, 5, 1);
    cpuWr(3'd4, 32'(ctl(1, 1, 0, 1)));
    while (!memReq) @(negedge clk);
    pulseReq(); pulseReq(); pulseReq();
    waitQuiet();
    check(nWrite == 16, "R8 one pending request", nWrite, 16);
    check(!irqDone && monErr == 0, "R8 no early irq", irqDone, 0);

    // same-cycle soft start and hardware request
    prog(32'h4000, 32'h9200, 3, 2, 1);
    cpuWr(3'd4, 32'(ctl(1, 0, 0, 1)));
    @(negedge clk);
    cpuWe = 1'b1; cpuAddr = 3'd4; cpuWdata = 32'(ctl(1, 1, 0, 1)); hwReq = 1'b1;
    @(negedge clk);
    cpuWe = 1'b0; hwReq = 1'b0;
    waitQuiet();
    check(nWrite == 6 && irqDone, "R6 R8 simultaneous triggers", nWrite, 6);

    // disabled channel ignores requests
    prog(32'h5000, 32'h9300, 2, 2, 1);
    pulseReq(); pulseReq(); waitQuiet();
    check(nWrite == 0, "R7 requests ignored when disabled", nWrite, 0);
    cpuWr(3'd4, 32'(ctl(1, 0, 0, 1)));
    waitQuiet();
    check(nWrite == 0, "R7 no remembered request", nWrite, 0);

    // abort mid burst
    prog(32'h6000, 32'h9400, 20, 1, 1);
    cpuWr(3'd4, 32'(ctl(1, 1, 0, 1)));
    while (!memReq) @(negedge clk);
    repeat (5) @(negedge clk);
    cpuWr(3'd4, 32'(ctl(0, 0, 0, 1)));
    check(!memReq, "R7 disable stops bus", memReq, 0);
    waitQuiet();
    check(nWrite < 20 && !irqDone, "R7 burst aborted", nWrite, 19);

    // zero beat count means full range
    prog(32'h7000, 32'h9500, 0, 1, 1);
    cpuWr(3'd4, 32'(ctl(1, 1, 0, 1)));
    waitQuiet();
    check(nWrite == FULL && monErr == 0, "R4 beat count zero", nWrite, FULL);
    check(irqDone, "R4 single burst done", irqDone, 1);

    // zero burst count means full range
    prog(32'h0, 32'h9600, 1, 0, 1);
    cpuWr(3'd4, 32'(ctl(1, 1, 0, 1)));
    waitQuiet();
    for (int i = 1; i < FULL; i++) begin pulseReq(); waitQuiet(); end
    check(nWrite == FULL && irqDone, "R4 burst count zero", nWrite, FULL);
    pulseReq(); waitQuiet();
    check(nWrite == FULL, "R5 extra request ignored", nWrite, FULL);
    cpuWr(3'd4, 32'(ctl(0, 0, 0, 0)));
    check(!irqDone, "R7 disable clears irq", irqDone, 0);

    // random programs
    for (int it = 0; it < 8; it++) begin
      int a = 1 + int'($urandom % 6);
      int b = 1 + int'($urandom % 4);
      bit stp = bit'($urandom % 2);
      logic [31:0] s = {$urandom % 32'h10000, 2'b00};
      prog(s, 32'hA000 + 32'(it * 4), a, b, stp);
      cpuWr(3'd4, 32'(ctl(1, 1, 0, stp)));
      waitQuiet();
      for (int k = 1; k < b; k++) begin pulseReq(); waitQuiet(); end
      check(nWrite == a * b, "R2 R4 random beat total", nWrite, a * b);
      check(monErr == 0, "R10 random ordering and addresses", monErr, 0);
      check(irqDone, "R5 random completion", irqDone, 1);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule